// File: doc/BRIEF.md
# Serial EEPROM Configuration Autoloader

This block fills a device's station-address bytes and its configuration registers from a serial EEPROM after reset. While reset is held, it watches a shared clock/LED pin. If that pin reads high, the block assumes an EEPROM is fitted and reads a 36-byte image as 18 sixteen-bit words over a four-wire serial link (chip select, serial clock, data to the EEPROM, data from the EEPROM).

Address bytes are written as they arrive. Configuration words go into a shadow buffer and are copied into the live registers only once the 8-bit image sum has been checked. A host can request a reload at any later time. While a load runs, the busy flag (`pread`) tells the bus side to retry I/O accesses. Configuration-space accesses are never retried.

Controller states are BOOT, IDLE, ISSUE, WAIT and CHECK. The transitions are:
- BOOT→ISSUE when a device was sensed, and BOOT→IDLE when none was.
- IDLE→ISSUE on a reload request.
- ISSUE→WAIT when a word read starts.
- WAIT→ISSUE when a word is done and more remain, and WAIT→CHECK after the last word.
- CHECK→IDLE.

The word reader has its own states IDLE, SHIFT and GAP, with the transitions IDLE→SHIFT on start, SHIFT→GAP after the last bit, and GAP→IDLE after one serial-clock period.

Top module: `eecfg_loader`

## Requirements
- R1: `ee_sense` is sampled on every clock edge while `rst_n` is low, and the last sample decides presence. If it is 0, the block never raises `ee_cs`, `pread` and `pvalid` stay 0, all address bytes are 0 and `cfg_regs` holds its defaults (reg0=0x0002, reg1=0x0080, reg2=0x2101, reg3=0x0000, reg4=0x9A05).
- R2: If a device was sensed, a load starts after reset is released, with `pread`=1 throughout. Each word read holds `ee_cs` high and sends 9 bits MSB first on `ee_di`: 1, 1, 0, then the 6-bit word address. It then takes 16 data bits MSB first from `ee_do`. All bits are sampled on the rising edge of `ee_sk`. A load reads words 0 to 17 in order.
- R3: `ee_sk` is low whenever `ee_cs` is low. `ee_cs` stays low for at least 2*SCK_HALF clock cycles between words.
- R4: The low byte of word n is image byte 2n and the high byte is byte 2n+1. Bytes 0–15 go to address bytes 0–15 (`sta_addr[8*i+:8]`). Bytes 16–25 form config regs 0–4, low byte first (`cfg_regs[16*i+:16]`).
- R5: If the mod-256 sum of all 36 bytes equals 0xFF, all five config regs take their new values in the same cycle, `pvalid` becomes 1 and `pread` becomes 0.
- R6: If the sum differs, `pread` and `pvalid` become 0 and the config regs return to their defaults. The address bytes keep the values that were loaded.
- R7: During a load the config regs change only by host write. Loaded words are not visible in `cfg_regs` until the checksum passes.
- R8: A host write to address 21 with data bit 0 set starts a full reload from IDLE and clears `pvalid`. The same request during a load is ignored, and each load reads exactly 18 words.
- R9: `acc_retry` is 1 when `acc_req`=1, `acc_is_cfg`=0 and `pread`=1. It is 0 for every configuration-space access.
- R10: Host writes to addresses 0–15 set the addressed station byte from `host_wdata[7:0]`, but only while bit 8 of config reg 0 is set. Addresses 16–20 write config regs 0–4.
- R11: A device wrongly sensed as present whose data line reads constant 1 ends the load as a checksum failure (as in R6), with every address byte at 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ee_sense | input | 1 | Level of the shared serial-clock/LED pin, sampled during reset |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | HA_W | Host register index (0–15 address bytes, 16–20 config, 21 control) |
| host_wdata | input | 16 | Host write data |
| acc_req | input | 1 | A bus access is being presented |
| acc_is_cfg | input | 1 | The access targets configuration space |
| acc_retry | output | 1 | The access must be retried |
| pread | output | 1 | Load in progress |
| pvalid | output | 1 | Last load passed its checksum |
| sta_addr | output | 8*N_STA | Station-address bytes, byte i at [8*i+:8] |
| cfg_regs | output | 16*N_CFG | Configuration registers, reg i at [16*i+:16] |

## Verification
The load is tried with several images whose bytes are random and whose last byte is set so the sum is 0xFF. Each of these shows the byte-to-register mapping and the committed values. An image with one flipped bit separates a checksum failure, which restores defaults but keeps the loaded address bytes, from a pass. An absent device and a stuck-high data line separate the "no serial activity" path from the "read and fail" path. A host write to a config register made before a reload, checked in the middle of that load, shows whether loaded data leaks before commit.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;
    typedef enum logic [2:0] {
        LD_BOOT,
        LD_IDLE,
        LD_ISSUE,
        LD_WAIT,
        LD_CHECK
    } ld_state_t;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_SHIFT,
        RD_GAP
    } rd_state_t;

    // start bit followed by the read opcode
    localparam logic [2:0] MW_READ_HDR = 3'b110;
    localparam logic [7:0] SUM_GOOD    = 8'hFF;
endpackage

// File: rtl/eecfg_tick.sv
module eecfg_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/eecfg_word_rd.sv
module eecfg_word_rd
    import eecfg_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic [AW-1:0] addr,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          ee_cs,
    output logic          ee_sk,
    output logic          ee_di,
    input  logic          ee_do
);
    localparam int CMD_W = 3 + AW;
    localparam int TOT   = CMD_W + DW;
    localparam int BW    = $clog2(TOT + 1);
    localparam logic [BW-1:0] LAST_B  = BW'(TOT - 1);
    localparam logic [BW-1:0] FIRST_D = BW'(CMD_W);

    rd_state_t        st_q, st_d;
    logic [BW-1:0]    bit_q;
    logic [CMD_W-1:0] cmd_q;
    logic [DW-1:0]    sh_q;
    logic             cs_q, sk_q, gap_q, done_q;

    assign busy  = (st_q != RD_IDLE);
    assign done  = done_q;
    assign rdata = sh_q;
    assign ee_cs = cs_q;
    assign ee_sk = sk_q;
    assign ee_di = cs_q & cmd_q[CMD_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RD_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RD_IDLE:  if (start) st_d = RD_SHIFT;
            RD_SHIFT: if (tick && sk_q && bit_q == LAST_B) st_d = RD_GAP;
            RD_GAP:   if (tick && gap_q) st_d = RD_IDLE;
            default:  st_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= '0;
            cmd_q  <= '0;
            sh_q   <= '0;
            cs_q   <= 1'b0;
            sk_q   <= 1'b0;
            gap_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                RD_IDLE: begin
                    if (start) begin
                        cs_q  <= 1'b1;
                        sk_q  <= 1'b0;
                        bit_q <= '0;
                        cmd_q <= {MW_READ_HDR, addr};
                    end
                end
                RD_SHIFT: begin
                    if (tick) begin
                        if (!sk_q) begin
                            sk_q <= 1'b1;
                            if (bit_q >= FIRST_D) sh_q <= {sh_q[DW-2:0], ee_do};
                        end else begin
                            sk_q  <= 1'b0;
                            cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
                            if (bit_q == LAST_B) begin
                                cs_q  <= 1'b0;
                                gap_q <= 1'b0;
                            end else begin
                                bit_q <= bit_q + 1'b1;
                            end
                        end
                    end
                end
                RD_GAP: begin
                    if (tick) begin
                        gap_q <= 1'b1;
                        if (gap_q) done_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: the serial clock never toggles with chip select low
    a_r3_sk_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sk);
    // R3: chip select stays low after falling for more than one cycle
    a_r3_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_cs) |=> !ee_cs);
    // R2: a new word is only accepted with chip select low
    a_r2_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |-> !ee_cs);
endmodule

// File: rtl/eecfg_loader.sv
module eecfg_loader
    import eecfg_pkg::*;
#(
    parameter int SCK_HALF  = 2,
    parameter int N_STA     = 16,
    parameter int N_CFG     = 5,
    parameter int IMG_BYTES = 36,
    parameter int WE_BIT    = 8,
    parameter int HA_W      = $clog2(N_STA + N_CFG + 1),
    parameter logic [16*N_CFG-1:0] CFG_RST = 80'h9A05_0000_2101_0080_0002
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ee_sense,
    output logic                 ee_cs,
    output logic                 ee_sk,
    output logic                 ee_di,
    input  logic                 ee_do,
    input  logic                 host_wr,
    input  logic [HA_W-1:0]      host_addr,
    input  logic [15:0]          host_wdata,
    input  logic                 acc_req,
    input  logic                 acc_is_cfg,
    output logic                 acc_retry,
    output logic                 pread,
    output logic                 pvalid,
    output logic [8*N_STA-1:0]   sta_addr,
    output logic [16*N_CFG-1:0]  cfg_regs
);
    localparam int AW      = 6;
    localparam int N_WORDS = IMG_BYTES / 2;
    localparam int WIDX_W  = $clog2(N_WORDS + 1);
    localparam int CFG_W0  = N_STA / 2;
    localparam logic [WIDX_W-1:0] LAST_W   = WIDX_W'(N_WORDS - 1);
    localparam logic [HA_W-1:0]   CTRL_IDX = HA_W'(N_STA + N_CFG);

    ld_state_t         state_q, state_d;
    logic              present_q;
    logic [WIDX_W-1:0] widx_q;
    logic [7:0]        sum_q;
    logic              pread_q, pvalid_q;
    logic [7:0]        sta_q [N_STA];
    logic [15:0]       cfg_q [N_CFG];
    logic [15:0]       shd_q [N_CFG];

    logic        tick, rd_busy, rd_done, rd_start;
    logic [15:0] rd_data;
    logic        reload_req, start_load;

    eecfg_tick #(.HALF(SCK_HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rd_busy),
        .tick  (tick)
    );

    eecfg_word_rd #(.AW(AW), .DW(16)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .start (rd_start),
        .addr  ({{(AW-WIDX_W){1'b0}}, widx_q}),
        .busy  (rd_busy),
        .done  (rd_done),
        .rdata (rd_data),
        .ee_cs (ee_cs),
        .ee_sk (ee_sk),
        .ee_di (ee_di),
        .ee_do (ee_do)
    );

    assign reload_req = host_wr && (host_addr == CTRL_IDX) && host_wdata[0];
    assign start_load = ((state_q == LD_BOOT) && present_q) ||
                        ((state_q == LD_IDLE) && reload_req);
    assign rd_start   = (state_q == LD_ISSUE);

    assign pread     = pread_q;
    assign pvalid    = pvalid_q;
    assign acc_retry = acc_req && !acc_is_cfg && pread_q;

    generate
        for (genvar g = 0; g < N_STA; g++) begin : g_sta
            assign sta_addr[8*g +: 8] = sta_q[g];
        end
        for (genvar g = 0; g < N_CFG; g++) begin : g_cfg
            assign cfg_regs[16*g +: 16] = cfg_q[g];
        end
    endgenerate

    // presence is the level on the shared pin at the last edge of reset
    always_ff @(posedge clk) begin
        if (!rst_n) present_q <= ee_sense;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LD_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_BOOT:  state_d = present_q ? LD_ISSUE : LD_IDLE;
            LD_IDLE:  if (reload_req) state_d = LD_ISSUE;
            LD_ISSUE: state_d = LD_WAIT;
            LD_WAIT:  if (rd_done) state_d = (widx_q == LAST_W) ? LD_CHECK : LD_ISSUE;
            LD_CHECK: state_d = LD_IDLE;
            default:  state_d = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pread_q  <= 1'b0;
            pvalid_q <= 1'b0;
            widx_q   <= '0;
            sum_q    <= '0;
            for (int i = 0; i < N_STA; i++) sta_q[i] <= '0;
            for (int i = 0; i < N_CFG; i++) begin
                cfg_q[i] <= CFG_RST[16*i +: 16];
                shd_q[i] <= '0;
            end
        end else begin
            if (host_wr) begin
                for (int i = 0; i < N_STA; i++)
                    if (host_addr == HA_W'(i) && cfg_q[0][WE_BIT]) sta_q[i] <= host_wdata[7:0];
                for (int i = 0; i < N_CFG; i++)
                    if (host_addr == HA_W'(N_STA + i)) cfg_q[i] <= host_wdata;
            end
            if (start_load) begin
                pread_q  <= 1'b1;
                pvalid_q <= 1'b0;
                widx_q   <= '0;
                sum_q    <= '0;
            end
            unique case (state_q)
                LD_WAIT: begin
                    if (rd_done) begin
                        sum_q  <= sum_q + rd_data[7:0] + rd_data[15:8];
                        widx_q <= widx_q + 1'b1;
                        for (int i = 0; i < N_STA / 2; i++) begin
                            if (widx_q == WIDX_W'(i)) begin
                                sta_q[2*i]   <= rd_data[7:0];
                                sta_q[2*i+1] <= rd_data[15:8];
                            end
                        end
                        for (int i = 0; i < N_CFG; i++)
                            if (widx_q == WIDX_W'(CFG_W0 + i)) shd_q[i] <= rd_data;
                    end
                end
                LD_CHECK: begin
                    pread_q <= 1'b0;
                    if (sum_q == SUM_GOOD) begin
                        pvalid_q <= 1'b1;
                        for (int i = 0; i < N_CFG; i++) cfg_q[i] <= shd_q[i];
                    end else begin
                        pvalid_q <= 1'b0;
                        for (int i = 0; i < N_CFG; i++) cfg_q[i] <= CFG_RST[16*i +: 16];
                    end
                end
                default: ;
            endcase
        end
    end

    // R1: absent device leaves the block idle with no serial activity
    a_r1_absent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_BOOT && !present_q) |=> (!pread_q && !ee_cs));
    // R2: busy flag covers every word transfer
    a_r2_busy_during_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_ISSUE || state_q == LD_WAIT) |-> pread_q);
    // R5: passing sum ends the load as valid
    a_r5_pass_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_CHECK && sum_q == SUM_GOOD) |=> (pvalid_q && !pread_q));
    // R6: failing sum restores configuration defaults
    a_r6_fail_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_CHECK && sum_q != SUM_GOOD) |=> (!pvalid_q && cfg_regs == CFG_RST));
    // R7: loaded words stay hidden until commit
    a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == LD_ISSUE || state_q == LD_WAIT) && !host_wr) |=> $stable(cfg_regs));
    // R9: configuration-space accesses are never retried
    a_r9_cfg_no_retry: assert property (@(posedge clk) disable iff (!rst_n)
        acc_is_cfg |-> !acc_retry);
    // R5: valid and busy are never both set
    a_r5_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(pvalid_q && pread_q));
endmodule

// File: tb/sim_eecfg_loader.sv
module sim_eecfg_loader;
    localparam int SCK_HALF = 2;
    localparam logic [79:0] DEF = 80'h9A05_0000_2101_0080_0002;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ee_sense = 1'b0;
    logic        ee_cs, ee_sk, ee_di, ee_do;
    logic        host_wr = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        acc_req = 1'b0, acc_is_cfg = 1'b0;
    logic        acc_retry, pread, pvalid;
    logic [127:0] sta_addr;
    logic [79:0]  cfg_regs;

    always #10 clk = ~clk;

    eecfg_loader #(.SCK_HALF(SCK_HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .ee_sense(ee_sense),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .acc_req(acc_req), .acc_is_cfg(acc_is_cfg), .acc_retry(acc_retry),
        .pread(pread), .pvalid(pvalid), .sta_addr(sta_addr), .cfg_regs(cfg_regs)
    );

    // EEPROM model
    logic [7:0]  img [36];
    logic        dev_on = 1'b0, stuck = 1'b0, do_r = 1'b0;
    int          mcnt = 0, nxt = 0, bad_cmd = 0, words = 0;
    logic [8:0]  cmd_acc = '0;
    int          cur_a = 0;
    logic [15:0] mw;

    assign ee_do = stuck ? 1'b1 : (dev_on ? do_r : 1'b0);

    always @(posedge ee_sk) begin
        if (mcnt < 9) cmd_acc = {cmd_acc[7:0], ee_di};
        mcnt++;
        if (mcnt == 9) begin
            cur_a = int'(cmd_acc[5:0]);
            if (cmd_acc[8:6] != 3'b110 || cur_a != nxt) bad_cmd++;
            nxt = (nxt + 1) % 18;
            words++;
        end
        if (mcnt == 25) mcnt = 0;
    end

    always @(negedge ee_sk) begin
        if (mcnt >= 9 && mcnt <= 24) begin
            mw   = (cur_a < 18) ? {img[2*cur_a+1], img[2*cur_a]} : 16'h0000;
            do_r = mw[24-mcnt];
        end
    end

    int   gap_run = 0, min_gap = 1000000, cs_rises = 0;
    logic cs_prev = 1'b0;
    always @(posedge clk) begin
        if (!ee_cs) gap_run++;
        else begin
            if (gap_run > 0 && gap_run < min_gap) min_gap = gap_run;
            gap_run = 0;
        end
        if (ee_cs && !cs_prev) cs_rises++;
        cs_prev = ee_cs;
    end

    int checks = 0, errs = 0;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input int a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 5'(a); host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic do_reset(input logic sense);
        rst_n = 1'b0; ee_sense = sense;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        repeat (3) @(negedge clk);
        while (pread && n < 8000) begin @(negedge clk); n++; end
        chk(tag, 128'(pread), 128'(0));
    endtask

    task automatic make_image(input bit good);
        logic [7:0] s = 8'h00;
        for (int i = 0; i < 35; i++) begin img[i] = 8'($urandom); s = s + img[i]; end
        img[35] = 8'hFF - s;
        if (!good) img[35] = img[35] ^ 8'h01;
    endtask

    function automatic logic [127:0] exp_sta();
        logic [127:0] r = '0;
        for (int i = 0; i < 16; i++) r[8*i +: 8] = img[i];
        return r;
    endfunction

    function automatic logic [127:0] exp_cfg();
        logic [127:0] r = '0;
        for (int i = 0; i < 5; i++) r[16*i +: 16] = {img[17+2*i], img[16+2*i]};
        return r;
    endfunction

    initial begin
        #3000000;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs + 1, checks + 1);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 36; i++) img[i] = 8'h00;

        // R1: no device
        do_reset(1'b0);
        repeat (60) @(negedge clk);
        chk("R1 pread", 128'(pread), 0);
        chk("R1 pvalid", 128'(pvalid), 0);
        chk("R1 cfg defaults", 128'(cfg_regs), 128'(DEF));
        chk("R1 sta cleared", sta_addr, 0);
        chk("R1 no chip select", 128'(cs_rises), 0);

        // R10: station-byte write gate
        host_write(3, 16'h005A);
        chk("R10 sta locked", 128'(sta_addr[31:24]), 0);
        host_write(16, 16'h0102);
        chk("R10 cfg0 write", 128'(cfg_regs[15:0]), 128'h0102);
        host_write(3, 16'h005A);
        chk("R10 sta unlocked", 128'(sta_addr[31:24]), 128'h5A);
        host_write(18, 16'h7777);
        chk("R10 cfg2 write", 128'(cfg_regs[47:32]), 128'h7777);

        // R2/R4/R5: good image after reset
        make_image(1'b1);
        dev_on = 1'b1;
        base = words;
        do_reset(1'b1);
        repeat (200) @(negedge clk);
        chk("R2 busy during load", 128'(pread), 1);
        acc_req = 1'b1; acc_is_cfg = 1'b0; #1;
        chk("R9 io retried", 128'(acc_retry), 1);
        acc_is_cfg = 1'b1; #1;
        chk("R9 cfg not retried", 128'(acc_retry), 0);
        acc_req = 1'b0; acc_is_cfg = 1'b0;
        chk("R7 cfg hidden mid-load", 128'(cfg_regs), 128'(DEF));
        wait_done("R2 load ends");
        chk("R5 pvalid", 128'(pvalid), 1);
        chk("R5 cfg committed", 128'(cfg_regs), exp_cfg());
        chk("R4 sta loaded", sta_addr, exp_sta());
        chk("R2 word count", 128'(words - base), 18);
        chk("R2 command framing", 128'(bad_cmd), 0);
        chk("R3 gap ok", 128'(min_gap >= 2 * SCK_HALF), 1);
        acc_req = 1'b1; #1;
        chk("R9 no retry when idle", 128'(acc_retry), 0);
        acc_req = 1'b0;

        // R8: host-triggered reloads
        for (int k = 0; k < 2; k++) begin
            host_write(17, 16'hBEEF);
            make_image(1'b1);
            base = words;
            host_write(21, 16'h0001);
            repeat (300) @(negedge clk);
            chk("R8 reload busy", 128'(pread), 1);
            chk("R8 pvalid cleared", 128'(pvalid), 0);
            chk("R7 cfg1 untouched mid-load", 128'(cfg_regs[31:16]), 128'hBEEF);
            host_write(21, 16'h0001);
            wait_done("R8 reload ends");
            chk("R8 single pass", 128'(words - base), 18);
            chk("R5 reload cfg", 128'(cfg_regs), exp_cfg());
            chk("R4 reload sta", sta_addr, exp_sta());
            chk("R5 reload valid", 128'(pvalid), 1);
        end
        chk("R2 framing after reloads", 128'(bad_cmd), 0);

        // R6: bad checksum
        make_image(1'b0);
        host_write(21, 16'h0001);
        wait_done("R6 load ends");
        chk("R6 pvalid", 128'(pvalid), 0);
        chk("R6 cfg defaults", 128'(cfg_regs), 128'(DEF));
        chk("R6 sta kept", sta_addr, exp_sta());

        // R11: pulled-up pin, no device
        dev_on = 1'b0; stuck = 1'b1;
        do_reset(1'b1);
        wait_done("R11 no hang");
        chk("R11 pvalid", 128'(pvalid), 0);
        chk("R11 cfg defaults", 128'(cfg_regs), 128'(DEF));
        chk("R11 sta all ones", sta_addr, {128{1'b1}});

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule